// File: doc/BRIEF.md
# Two-Wire Control-Port Receiver

This block is a write-only slave on a two-wire serial bus. It takes commands for a multi-function audio control chip. It samples the clock and data lines with the system clock and removes short glitches from both. It then detects start and stop conditions and collects bytes MSB first. It drives an acknowledge on the ninth clock of every byte once its chip address has matched.

After the address byte, the top bit of each byte decides what the byte is. A zero marks a function select, which picks one of nine control functions and may turn on incremental mode. A one marks a value, whose low seven bits are written to the current function. The function select stays in force for any number of values. In incremental mode each value first advances the function index, wrapping from 8 back to 0. Each accepted value appears as a one-cycle write strobe together with the function index and the 7-bit payload.

Top module: `ctl_port_rx`

## Requirements
- R1: A falling data line while the clock is high is a start and begins address reception. A rising data line while the clock is high is a stop and returns the slave to idle.
- R2: The first byte after a start is acknowledged only when it equals 0x80 (addr_sel = 0) or 0x82 (addr_sel = 1). This means bit 0, the direction bit, must be 0.
- R3: After a non-matching address, including one with bit 0 set, the slave drives no acknowledge and issues no write strobe until the next start.
- R4: Once the address has matched, every byte is acknowledged. sda_pull rises only while the filtered clock is low, and it covers the whole high time of the ninth clock.
- R5: A byte with bit 7 = 0 selects a function. Take c = {bit4, bit5, bit6}. If c < 7, the index is c (0 volume, 1 surround/effect, 2 bass, 3 treble, 4 speaker right, 5 speaker left, 6 aux right). If c = 7, bit 3 chooses 7 (aux left, bit 3 = 0) or 8 (input stage, bit 3 = 1).
- R6: A byte with bit 7 = 1 is a value. It produces exactly one wr_stb pulse of one cycle, with wr_func set to the current index and wr_data set to bits 6..0.
- R7: Without incremental mode, any number of values in one transfer all go to the last selected function.
- R8: Bit 0 of a select byte turns on incremental mode. Each value then advances the index by one before it is written, and the index wraps from 8 to 0.
- R9: A stop turns incremental mode off, but the function index is kept for the next transfer.
- R10: A start in the middle of a byte drops that byte without a strobe and restarts address reception.
- R11: A pulse shorter than three system clocks on either bus line produces no bit and no start or stop condition.
- R12: After reset, sda_pull and wr_stb are low, the function index is 0 and incremental mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 1 | Chooses address byte 0x82 (1) or 0x80 (0) |
| sda_pull | output | 1 | Drive the data line low (open-drain enable) |
| wr_stb | output | 1 | One-cycle strobe for an accepted value |
| wr_func | output | 4 | Function index of the write, 0..8 |
| wr_data | output | 7 | Payload of the write |

## Verification
The directed transfers pair each address byte with both settings of addr_sel, and one of them sets the direction bit. Together they separate a full-byte address compare from a partial one. Select bytes that cover every code, including both sides of the bit-3 split, show that the decode is correct and that incremental mode wraps from input stage to volume. Transfers that start with values and no select show whether the index and mode survive a stop. An abort in the middle of a byte and glitches injected on both lines show whether the byte framing and the line filters hold. Seeded random transfers mix selects and values in arbitrary order and compare every strobe with a bench model.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int FUNC_W   = 4;
  localparam int PAY_W    = 7;
  localparam int LAST_FN  = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_BODY, ST_SKIP} rx_state_t;

  // function index from a select byte: bits 4,5,6 form a 3-bit code,
  // code 7 is split in two by bit 3
  function automatic logic [FUNC_W-1:0] fn_decode(input logic [7:0] b);
    logic [2:0] code;
    code = {b[4], b[5], b[6]};
    if (code == 3'd7) fn_decode = b[3] ? FUNC_W'(8) : FUNC_W'(7);
    else              fn_decode = {1'b0, code};
  endfunction

  function automatic logic [FUNC_W-1:0] fn_next(input logic [FUNC_W-1:0] i);
    fn_next = (i >= FUNC_W'(LAST_FN)) ? '0 : i + FUNC_W'(1);
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic sel);
    addr_hit = (b == {6'b100000, sel, 1'b0});
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic clean
);
  localparam logic [FILT_LEN-1:0] ALL1 = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist;
  logic agree_hi, agree_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist   <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      hist   <= {hist[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (agree_hi)      clean <= 1'b1;
      else if (agree_lo) clean <= 1'b0;
    end
  end

  assign agree_hi = (hist == ALL1);
  assign agree_lo = (hist == '0);

  // R11: the clean line moves only after a full window of equal samples
  a_r11_filter_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean) |-> $past(agree_hi || agree_lo));
endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  // R1: a condition needs the clock high on both samples, never with an edge
  a_r1_cond_no_clock_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> !(scl_rise || scl_fall));
endmodule

// File: rtl/ctl_port_rx.sv
module ctl_port_rx
  import ctl_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_sel,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [FUNC_W-1:0] wr_func,
  output logic [PAY_W-1:0]  wr_data
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  rx_state_t         state;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic              ack_phase;
  logic              inc_mode;
  logic [FUNC_W-1:0] func_idx;

  // events brought out for the assertions
  logic byte_done, is_value, addr_ok;
  logic [FUNC_W-1:0] value_idx;

  line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .pin(scl_in), .clean(scl_f));
  line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .pin(sda_in), .clean(sda_f));

  bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  assign byte_done = scl_fall && !ack_phase && (bit_cnt == BYTE_BITS) &&
                     (state == ST_ADDR || state == ST_BODY);
  assign is_value  = shreg[7];
  assign addr_ok   = addr_hit(shreg, addr_sel);
  assign value_idx = inc_mode ? fn_next(func_idx) : func_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      ack_phase <= 1'b0;
      sda_pull  <= 1'b0;
      inc_mode  <= 1'b0;
      func_idx  <= '0;
      wr_stb    <= 1'b0;
      wr_func   <= '0;
      wr_data   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        ack_phase <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_ev) begin
        state     <= ST_IDLE;
        ack_phase <= 1'b0;
        sda_pull  <= 1'b0;
        inc_mode  <= 1'b0;
      end else if (state == ST_ADDR || state == ST_BODY) begin
        if (scl_rise && !ack_phase && bit_cnt < BYTE_BITS) begin
          shreg   <= {shreg[6:0], sda_f};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && ack_phase) begin
          sda_pull  <= 1'b0;
          ack_phase <= 1'b0;
          bit_cnt   <= '0;
        end else if (byte_done) begin
          if (state == ST_ADDR) begin
            if (addr_ok) begin
              state     <= ST_BODY;
              sda_pull  <= 1'b1;
              ack_phase <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end else begin
            sda_pull  <= 1'b1;
            ack_phase <= 1'b1;
            if (!is_value) begin
              func_idx <= fn_decode(shreg);
              inc_mode <= shreg[0];
            end else begin
              func_idx <= value_idx;
              wr_stb   <= 1'b1;
              wr_func  <= value_idx;
              wr_data  <= shreg[6:0];
            end
          end
        end
      end
    end
  end

  // R4: the acknowledge drive only changes while the clock is low
  a_r4_pull_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);
  // R3: no drive and no write outside an addressed transfer
  a_r3_quiet_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP || state == ST_IDLE) |-> !sda_pull && !wr_stb);
  // R6: a write strobe is a single cycle
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R5: the function index never leaves 0..8
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_func <= FUNC_W'(LAST_FN));
  // R1: start and stop cannot coincide
  a_r1_exclusive_cond: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
  // R8: an incremental write lands one past the previous index
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_BODY && is_value && inc_mode) |=>
      wr_func == fn_next($past(func_idx)));
endmodule

// File: tb/test_ctl_port_rx.sv
module test_ctl_port_rx;
  localparam int H = 20;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic addr_sel = 1'b0;
  logic sda_pull, wr_stb;
  logic [3:0] wr_func;
  logic [6:0] wr_data;
  wire sda_line = !(m_low || sda_pull);

  always #10 clk = ~clk;

  ctl_port_rx i_ctl_port_rx (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .wr_stb(wr_stb),
    .wr_func(wr_func), .wr_data(wr_data));

  int total = 0, bad = 0;
  int n_got = 0, n_exp = 0;
  logic [3:0] got_f [0:1023];
  logic [6:0] got_v [0:1023];
  logic [3:0] exp_f [0:1023];
  logic [6:0] exp_v [0:1023];
  logic [3:0] m_idx = 0;
  logic m_inc = 0;
  bit done = 0;
  int pull_seen = 0;

  always @(negedge clk) if (wr_stb) begin
    got_f[n_got] = wr_func;
    got_v[n_got] = wr_data;
    n_got++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] b_decode(input logic [7:0] b);
    casez (b[6:3])
      4'b000?: return 4'd0;
      4'b100?: return 4'd1;
      4'b010?: return 4'd2;
      4'b110?: return 4'd3;
      4'b001?: return 4'd4;
      4'b101?: return 4'd5;
      4'b011?: return 4'd6;
      4'b1110: return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start();
    wt(Q); m_low = 0; wt(Q); m_scl = 1; wt(H); m_low = 1; wt(H); m_scl = 0;
  endtask

  task automatic b_stop();
    wt(Q); m_low = 1; wt(Q); m_scl = 1; wt(H); m_low = 0; wt(H);
  endtask

  task automatic b_bit(input logic v, input bit glitch);
    wt(Q); m_low = !v; wt(Q); m_scl = 1;
    if (glitch) begin
      wt(5); m_scl = 0; wt(2); m_scl = 1;
      wt(4); if (v) begin m_low = 1; wt(2); m_low = 0; end
      wt(3);
    end else wt(H);
    m_scl = 0;
  endtask

  task automatic b_byte(input logic [7:0] b, input int glitch_bit, output bit acked);
    for (int i = 7; i >= 0; i--) b_bit(b[i], i == glitch_bit);
    wt(Q); m_low = 0; wt(Q); m_scl = 1; pull_seen = 0;
    for (int k = 0; k < H; k++) begin
      wt(1); if (!sda_line) pull_seen++;
    end
    acked = (pull_seen == H);
    m_scl = 0;
  endtask

  // model of a body byte
  task automatic model(input logic [7:0] b);
    if (!b[7]) begin m_idx = b_decode(b); m_inc = b[0]; end
    else begin
      if (m_inc) m_idx = (m_idx == 4'd8) ? 4'd0 : m_idx + 4'd1;
      exp_f[n_exp] = m_idx; exp_v[n_exp] = b[6:0]; n_exp++;
    end
  endtask

  task automatic xfer(input logic [7:0] bytes [0:7], input int n, input string req,
                      input int glitch_at);
    bit ack;
    b_start();
    b_byte({6'b100000, addr_sel, 1'b0}, -1, ack);
    chk(ack, "R2 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      b_byte(bytes[i], (i == 0) ? glitch_at : -1, ack);
      chk(ack, "R4 byte ack", ack, 1);
      model(bytes[i]);
    end
    b_stop();
    m_inc = 0;
    wt(4);
    chk(n_got == n_exp, {req, " strobe count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_f[i] == exp_f[i], {req, " func"}, got_f[i], exp_f[i]);
      chk(got_v[i] == exp_v[i], {req, " data"}, got_v[i], exp_v[i]);
    end
    n_got = 0; n_exp = 0;
  endtask

  initial begin
    wt(2000000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] bb [0:7];
    bit ack;
    int seed, n;
    seed = $urandom(32'd1234);
    wt(5);
    chk(sda_pull == 0 && wr_stb == 0, "R12 reset outputs", sda_pull, 0);
    rst_n = 1; wt(20);
    chk(sda_pull == 0, "R12 idle pull", sda_pull, 0);

    // R12: value before any select goes to index 0
    bb[0] = 8'h85; xfer(bb, 1, "R12 default index", -1);
    // R5/R7: every select code, two values each
    for (int c = 0; c < 16; c++) begin
      bb[0] = {1'b0, c[3:0], 3'b010}; bb[1] = 8'hA3; bb[2] = 8'hFF;
      xfer(bb, 3, "R5 R7 decode sticky", -1);
    end
    // R8: increment wraps from input stage to volume
    bb[0] = 8'h7F; bb[1] = 8'h81; bb[2] = 8'h82; bb[3] = 8'h83;
    xfer(bb, 4, "R8 wrap", -1);
    bb[0] = 8'h01; bb[1] = 8'h90; bb[2] = 8'h91;
    xfer(bb, 3, "R8 first value plus one", -1);
    // R9: after stop, increment is off and the index stays
    bb[0] = 8'hC4; bb[1] = 8'hC5;
    xfer(bb, 2, "R9 stop clears increment", -1);
    // R11: glitches on both lines inside a byte
    bb[0] = 8'hB5; xfer(bb, 1, "R11 glitch", 5);
    bb[0] = 8'h30; bb[1] = 8'hFF; xfer(bb, 2, "R11 glitch select", 4);

    // R3: wrong address, and direction bit set
    addr_sel = 1;
    b_start(); b_byte(8'h80, -1, ack); chk(!ack, "R3 wrong address no ack", ack, 0);
    b_byte(8'h9A, -1, ack); chk(!ack, "R3 skipped byte no ack", ack, 0);
    b_stop(); wt(4); chk(n_got == 0, "R3 no strobe", n_got, 0);
    b_start(); b_byte(8'h83, -1, ack); chk(!ack, "R3 read bit no ack", ack, 0);
    b_byte(8'hC0, -1, ack); b_stop(); wt(4);
    chk(n_got == 0, "R3 no strobe read", n_got, 0);
    bb[0] = 8'h10; bb[1] = 8'hAA; xfer(bb, 2, "R2 address 0x82", -1);

    // R10: repeated start in the middle of a value byte
    b_start(); b_byte(8'h82, -1, ack);
    b_byte(8'h28, -1, ack); model(8'h28);
    for (int i = 7; i >= 4; i--) b_bit(1'b1, 0);
    b_start(); b_byte(8'h82, -1, ack); chk(ack, "R10 restart address", ack, 1);
    b_byte(8'h8E, -1, ack); model(8'h8E);
    b_stop(); m_inc = 0; wt(4);
    chk(n_got == 1 && got_f[0] == exp_f[0] && got_v[0] == exp_v[0],
        "R10 aborted byte dropped", n_got, 1);
    n_got = 0; n_exp = 0;

    // random mixed traffic
    for (int t = 0; t < 25; t++) begin
      n = 1 + $urandom_range(0, 5);
      for (int i = 0; i < n; i++) bb[i] = 8'($urandom);
      xfer(bb, n, "R6 random traffic", -1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule